// File: doc/BRIEF.md
# Single to Half Precision Rounding Converter

This block narrows a 32-bit single-precision floating-point bit pattern to a 16-bit half-precision bit pattern. It rounds to nearest with ties to even. Values too large for the narrow format become signed infinity. Values that fall below the smallest normal half are rounded into half subnormals or flushed to a signed zero. Every NaN input, quiet or signalling, leaves as a single canonical quiet NaN that keeps the input sign.

The datapath is combinational. A parameter selects whether the result and the valid flag pass through one output register or leave in the same cycle. The valid flag carries no handshake and only travels alongside the data. Rounding of subnormal results uses the same adder as normal results. The input exponent is clamped from below to the value that lines up with the half subnormal step, and the significand is shifted right by the extra distance before the rounding add.

Top module: `f32_to_f16_rne`

## Requirements
- R1: An input whose exponent field (bits 30:23) is 0xFF and whose mantissa field (bits 22:0) is nonzero produces 0x7E00 in output bits 14:0.
- R2: Infinite inputs, and finite inputs whose magnitude is 65520 or more, produce 0x7C00 in output bits 14:0. Inputs from 65504 up to just below 65520 produce 0x7BFF.
- R3: Normal half results use round to nearest, ties to even. The 13 discarded mantissa bits split into a guard bit (the highest) and a sticky OR of the rest. The result rounds up when the guard bit is set and either the sticky bit or the kept least significant bit is set.
- R4: Inputs with exponent field 102 to 112 produce half subnormals (exponent bits 14:10 equal to zero) with the same ties-to-even rule. For example, 2^-24 gives 0x0001, 1.5*2^-24 gives 0x0002, and exactly 2^-25 gives 0x0000.
- R5: Inputs with exponent field below 102 give 0x0000 in bits 14:0. This includes single-precision zeros and subnormals.
- R6: Output bit 15 equals input bit 31 in every case, including zero, infinity and NaN.
- R7: A carry out of the rounded mantissa increments the exponent field. The largest value below the minimum normal can round to 0x0400, a value just below 2.0 can round to 0x4000, and the top of the finite range can round to infinity.
- R8: With OUT_REG=1, out_bits and out_valid show the result of the inputs one clock edge later. While rst_n is low, both are held at zero. With OUT_REG=0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_bits as carrying a value |
| in_bits | input | 32 | Single-precision input bit pattern |
| out_valid | output | 1 | in_valid after the selected latency |
| out_bits | output | 16 | Half-precision result bit pattern |

## Verification
The assertions take for granted that in_bits holds a known pattern in any cycle where in_valid is high. Their input-side checks are qualified by in_valid. The registered-path checks also assume that in_valid is low while reset is applied, so that the first cycle after reset carries no stale value. The stimulus follows both rules. It drives in_valid low through reset, changes in_bits only on the falling clock edge together with a known value, and holds in_valid low in the one scenario that exercises the valid path with a data value present.

// File: rtl/f32_to_f16_rne.sv
module f32_to_f16_rne #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  output logic        out_valid,
  output logic [15:0] out_bits
);

  localparam int SE_W      = 8;
  localparam int SM_W      = 23;
  localparam int HE_W      = 5;
  localparam int HM_W      = 10;
  localparam int DROP      = SM_W - HM_W;
  localparam int MIN_NORM  = 113;
  localparam int OVF_EXP   = 143;
  localparam int MAX_EXTRA = 12;
  localparam int SIG_W     = SM_W + 1;
  localparam int WIDE_W    = SIG_W + 26;
  localparam logic [14:0] QNAN_MAG = 15'h7E00;
  localparam logic [14:0] INF_MAG  = 15'h7C00;

  logic            sgn;
  logic [SE_W-1:0] exp_in;
  logic [SM_W-1:0] man_in;
  logic            is_special, is_nan, is_ovf, is_zero;

  assign sgn    = in_bits[31];
  assign exp_in = in_bits[30:23];
  assign man_in = in_bits[22:0];

  assign is_special = (exp_in == 8'hFF);
  assign is_nan     = is_special && (man_in != '0);
  assign is_ovf     = !is_special && (exp_in >= 8'(OVF_EXP));
  assign is_zero    = (exp_in == 8'h00);

  logic [SE_W-1:0] exp_cl;
  logic [4:0]      extra;
  logic [5:0]      shamt;
  logic [HE_W-1:0] exp_fld;

  always_comb begin
    if (exp_in < 8'(MIN_NORM)) begin
      exp_cl = 8'(MIN_NORM);
      if (exp_in <= 8'(MIN_NORM - MAX_EXTRA))
        extra = 5'(MAX_EXTRA);
      else
        extra = 5'(8'(MIN_NORM) - exp_in);
    end else begin
      exp_cl = exp_in;
      extra  = '0;
    end
    shamt   = 6'(DROP) + {1'b0, extra};
    exp_fld = HE_W'(exp_cl - 8'(MIN_NORM));
  end

  logic [SIG_W-1:0]  sig;
  logic [WIDE_W-1:0] wide;
  logic [HM_W:0]     kept;
  logic              guard, sticky, rnd;
  logic [11:0]       man_rnd;
  logic [14:0]       fin_mag;

  assign sig     = {1'b1, man_in};
  assign wide    = {sig, 26'b0} >> shamt;
  assign kept    = wide[36:26];
  assign guard   = wide[25];
  assign sticky  = |wide[24:0];
  assign rnd     = guard && (sticky || kept[0]);
  assign man_rnd = {1'b0, kept} + {11'b0, rnd};
  assign fin_mag = {exp_fld, 10'b0} + {3'b0, man_rnd};

  logic [14:0] mag;
  logic [15:0] res;

  always_comb begin
    if (is_nan)                  mag = QNAN_MAG;
    else if (is_special || is_ovf) mag = INF_MAG;
    else if (is_zero)            mag = '0;
    else                         mag = fin_mag;
  end

  assign res = {sgn, mag};

  generate
    if (OUT_REG) begin : g_reg
      logic        v_q;
      logic [15:0] d_q;
      logic        primed;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q    <= 1'b0;
          d_q    <= '0;
          primed <= 1'b0;
        end else begin
          v_q    <= in_valid;
          d_q    <= res;
          primed <= 1'b1;
        end
      end
      assign out_valid = v_q;
      assign out_bits  = d_q;

      // R6
      sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && in_valid |=> out_bits[15] == $past(in_bits[31]));
      // R8
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> out_valid == $past(in_valid));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_bits  = res;
    end
  endgenerate

  // R1
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res[14:10] == 5'h1F && res[9:0] != '0) |-> res[9:0] == 10'h200);
  // R2
  overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exp_in >= 8'(OVF_EXP) && exp_in != 8'hFF |-> res[14:0] == INF_MAG);
  // R5
  tiny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exp_in < 8'd102 |-> res[14:0] == 15'h0);
  // R4
  subnorm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exp_in >= 8'd102 && exp_in < 8'(MIN_NORM) |-> res[14:0] <= 15'h0400);
  // R7
  finite_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && exp_in < 8'd142 |-> res[14:10] != 5'h1F);

endmodule

// File: tb/tb_f32_to_f16_rne.sv
module tb_f32_to_f16_rne;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic        out_valid;
  logic [15:0] out_bits;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  f32_to_f16_rne #(.OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_bits(out_bits)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input string req, input logic [31:0] a, input logic [15:0] exp);
    @(negedge clk);
    in_bits  = a;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check16(req, out_bits, exp);
    check16({req, " valid"}, {15'b0, out_valid}, 16'h1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    check16("R8 reset bits", out_bits, 16'h0);
    check16("R8 reset valid", {15'b0, out_valid}, 16'h0);
  endtask

  task automatic test_nan();
    conv("R1 quiet nan", 32'h7FC00000, 16'h7E00);
    conv("R1 signalling nan", 32'h7F800001, 16'h7E00);
    conv("R1 neg nan", 32'hFF800001, 16'hFE00);
    conv("R1 all ones", 32'hFFFFFFFF, 16'hFE00);
  endtask

  task automatic test_overflow();
    conv("R2 pos inf", 32'h7F800000, 16'h7C00);
    conv("R2 neg inf", 32'hFF800000, 16'hFC00);
    conv("R2 65536", 32'h47800000, 16'h7C00);
    conv("R2 max single", 32'h7F7FFFFF, 16'h7C00);
    conv("R2 65520", 32'h477FF000, 16'h7C00);
    conv("R2 -65520", 32'hC77FF000, 16'hFC00);
    conv("R2 65504", 32'h477FE000, 16'h7BFF);
    conv("R2 below 65520", 32'h477FEFFF, 16'h7BFF);
  endtask

  task automatic test_round();
    conv("R3 one", 32'h3F800000, 16'h3C00);
    conv("R3 tie to even down", 32'h3F801000, 16'h3C00);
    conv("R3 tie to even up", 32'h3F803000, 16'h3C02);
    conv("R3 above tie", 32'h3F801001, 16'h3C01);
    conv("R3 below tie", 32'h3F800FFF, 16'h3C00);
    conv("R3 minus pi", 32'hC0490FDB, 16'hC248);
  endtask

  task automatic test_subnormal();
    conv("R4 2^-24", 32'h33800000, 16'h0001);
    conv("R4 2^-25 tie", 32'h33000000, 16'h0000);
    conv("R4 above 2^-25", 32'h33000001, 16'h0001);
    conv("R4 1.5*2^-24 tie", 32'h33C00000, 16'h0002);
    conv("R4 largest subnormal", 32'h387FC000, 16'h03FF);
  endtask

  task automatic test_tiny();
    conv("R5 below half step", 32'h32FFFFFF, 16'h0000);
    conv("R5 single subnormal", 32'h00000001, 16'h0000);
    conv("R5 pos zero", 32'h00000000, 16'h0000);
  endtask

  task automatic test_sign();
    conv("R6 neg zero", 32'h80000000, 16'h8000);
    conv("R6 neg single subnormal", 32'h80400000, 16'h8000);
    conv("R6 neg 2^-24", 32'hB3800000, 16'h8001);
    conv("R6 neg two", 32'hC0000000, 16'hC000);
  endtask

  task automatic test_carry();
    conv("R7 to min normal", 32'h387FF000, 16'h0400);
    conv("R7 to two", 32'h3FFFF000, 16'h4000);
    conv("R7 into inf", 32'h477FF800, 16'h7C00);
  endtask

  task automatic test_valid();
    @(negedge clk);
    in_bits  = 32'h3F800000;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check16("R8 valid low passes", {15'b0, out_valid}, 16'h0);
    check16("R8 data still converted", out_bits, 16'h3C00);
    @(negedge clk);
    in_bits  = 32'h40000000;
    in_valid = 1'b1;
    #0.5;
    check16("R8 one cycle latency", out_bits, 16'h3C00);
    @(posedge clk);
    #1;
    check16("R8 after edge", out_bits, 16'h4000);
    check16("R8 valid after edge", {15'b0, out_valid}, 16'h1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_nan();
        test_overflow();
        test_round();
        test_subnormal();
        test_tiny();
        test_sign();
        test_carry();
        test_valid();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        test_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule